// File: doc/BRIEF.md
# Codec Serial Word Shifter

This block moves parallel words onto a codec serial link and collects serial words back into parallel form. It runs on the system clock. A bit clock generator outside the block supplies one-cycle strobes for the rising and falling bit-clock edges, and also supplies the frame sync line. Configuration inputs choose which bit-clock edge launches data, whether words travel most or least significant bit first, and which level of frame sync counts as active.

The transmitter has three states. `TX_IDLE` holds the data line low. A frame start moves it to `TX_ARMED`, where it loads the offered word, or zeros if no word is offered. The first launch edge moves it to `TX_SHIFT`, where it drives one bit per launch edge. After the last bit it returns to `TX_IDLE` on the next launch edge. Transmit enable going low sends it to `TX_IDLE` from any state, and a frame start sends it to `TX_ARMED` from any state.

The receiver also has three states. `RX_IDLE` waits. A frame start moves it to `RX_ARMED`. The first launch edge moves it to `RX_SHIFT`, where it takes one sample per capture edge. It returns to `RX_IDLE` after the last sample, and it publishes the word at that point. A frame start restarts it from any state.

Top module: `codec_shifter`

## Requirements
- R1: While reset is held, and in the first cycle after it, `txd`, `tx_ready`, `tx_underrun` and `rx_valid` are 0 and `rx_word` is all zeros.
- R2: With `cfg_clk_pol`=0 the launch edge is `bclk_rise` and the capture edge is `bclk_fall`. With `cfg_clk_pol`=1 the two are swapped. `txd` changes only in the cycle after a launch edge, a frame start, or a low `tx_en`.
- R3: Frame sync is active when `fsync` equals `cfg_fs_pol`, so 1 means active high and 0 means active low. A frame start is a cycle in which frame sync is active after being inactive in the previous cycle.
- R4: `tx_ready` is high, combinationally, exactly in a frame-start cycle while `tx_en` is 1. If `tx_valid` is also high in that cycle, `tx_word` is taken for the new slot.
- R5: With `cfg_lsb_first`=0 the slot sends bit W-1 first and continues downward. With 1 it sends bit 0 first and continues upward. The order is taken at frame start. Each bit appears on `txd` in the cycle after its launch edge.
- R6: After the W-th bit, the next launch edge drives `txd` low, and `txd` stays low until the next slot's first bit.
- R7: While `tx_en` is 0, `txd` is 0 from the next cycle on. The current slot is dropped, and sending resumes only at a frame start seen with `tx_en` high.
- R8: A frame start with `tx_en` high and `tx_valid` low produces a one-cycle `tx_underrun` pulse in the next cycle, and that slot sends W zeros.
- R9: After a frame start, the receiver waits for one launch edge. It then samples `rxd` on W capture edges. The k-th sample (k from 0) goes to bit W-1-k when MSB-first and to bit k when LSB-first, so `rx_word` is always in natural order.
- R10: `rx_valid` pulses for one cycle in the cycle after the W-th sample, and `rx_word` changes only at that point. The receiver runs whatever the value of `tx_en`.
- R11: A frame start during a word abandons it and restarts both directions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_clk_pol | input | 1 | Edge select: 0 launch on rise and capture on fall, 1 the reverse |
| cfg_lsb_first | input | 1 | Bit order: 0 MSB first, 1 LSB first |
| cfg_fs_pol | input | 1 | Level of `fsync` treated as active |
| tx_en | input | 1 | Transmit enable |
| tx_word | input | W | Word offered for the next slot |
| tx_valid | input | 1 | `tx_word` is valid |
| tx_ready | output | 1 | Word accepted this cycle (frame start) |
| txd | output | 1 | Serial transmit data |
| rxd | input | 1 | Serial receive data |
| rx_word | output | W | Last completed receive word |
| rx_valid | output | 1 | One-cycle strobe when `rx_word` updates |
| tx_underrun | output | 1 | One-cycle strobe when a slot starts with no word |
| bclk_rise | input | 1 | Rising bit-clock edge strobe |
| bclk_fall | input | 1 | Falling bit-clock edge strobe |
| fsync | input | 1 | Frame sync from the clock generator |

## Verification
The assertions assume that the rising and falling strobes never occur in the same cycle. They also assume that the configuration inputs change only between frames, and that no frame start coincides with a bit-clock strobe. The bench drives the bit clock as a four-cycle pattern: a rise strobe, a gap, a fall strobe, and a gap. It holds frame sync active only during the first bit period, with a quiet cycle before it. It changes polarity, bit order and frame polarity together with the inactive level of frame sync, so that a configuration change never produces a false frame start.

// File: rtl/codec_shift_pkg.sv
package codec_shift_pkg;

    typedef enum logic [1:0] {
        TX_IDLE  = 2'd0,
        TX_ARMED = 2'd1,
        TX_SHIFT = 2'd2
    } tx_state_t;

    typedef enum logic [1:0] {
        RX_IDLE  = 2'd0,
        RX_ARMED = 2'd1,
        RX_SHIFT = 2'd2
    } rx_state_t;

endpackage

// File: rtl/codec_edge_sel.sv
module codec_edge_sel (
    input  logic clk,
    input  logic rst_n,
    input  logic bclk_rise,
    input  logic bclk_fall,
    input  logic fsync,
    input  logic clk_pol,
    input  logic fs_pol,
    output logic tx_edge,
    output logic rx_edge,
    output logic frame_start
);

    logic fs_active;
    logic fs_active_q;

    // launch and capture always sit on opposite bit-clock edges
    always_comb begin
        if (clk_pol) begin
            tx_edge = bclk_fall;
            rx_edge = bclk_rise;
        end else begin
            tx_edge = bclk_rise;
            rx_edge = bclk_fall;
        end
    end

    assign fs_active = (fsync == fs_pol);

    // reset to "active" so a sync already asserted at reset exit is not a start
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) fs_active_q <= 1'b1;
        else        fs_active_q <= fs_active;
    end

    assign frame_start = fs_active & ~fs_active_q;

endmodule

// File: rtl/codec_tx_ser.sv
module codec_tx_ser
    import codec_shift_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tx_en,
    input  logic         frame_start,
    input  logic         tx_edge,
    input  logic         lsb_first,
    input  logic         tx_valid,
    input  logic [W-1:0] tx_word,
    output logic         txd,
    output logic         tx_underrun
);

    localparam int            CW   = $clog2(W + 1);
    localparam logic [CW-1:0] LAST = CW'(W);

    tx_state_t     st_q, st_d;
    logic [W-1:0]  sreg_q;
    logic [CW-1:0] cnt_q;
    logic          lsb_q;
    logic          txd_q;
    logic          und_q;
    logic          bits_left;
    logic          next_bit;
    logic [W-1:0]  sreg_shifted;

    assign bits_left = (st_q != TX_IDLE) && (cnt_q != LAST);

    generate
        if (W > 1) begin : g_wide
            assign next_bit     = lsb_q ? sreg_q[0] : sreg_q[W-1];
            assign sreg_shifted = lsb_q ? {1'b0, sreg_q[W-1:1]}
                                        : {sreg_q[W-2:0], 1'b0};
        end else begin : g_single
            assign next_bit     = sreg_q[0];
            assign sreg_shifted = '0;
        end
    endgenerate

    // next-state logic
    always_comb begin
        st_d = st_q;
        if (!tx_en) begin
            st_d = TX_IDLE;
        end else if (frame_start) begin
            st_d = TX_ARMED;
        end else if (tx_edge) begin
            unique case (st_q)
                TX_IDLE:  st_d = TX_IDLE;
                TX_ARMED: st_d = TX_SHIFT;
                TX_SHIFT: st_d = (cnt_q == LAST) ? TX_IDLE : TX_SHIFT;
                default:  st_d = TX_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= TX_IDLE;
        else        st_q <= st_d;
    end

    // datapath and outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sreg_q <= '0;
            cnt_q  <= '0;
            lsb_q  <= 1'b0;
            txd_q  <= 1'b0;
            und_q  <= 1'b0;
        end else begin
            und_q <= 1'b0;
            if (!tx_en) begin
                txd_q <= 1'b0;
                cnt_q <= '0;
            end else if (frame_start) begin
                sreg_q <= tx_valid ? tx_word : '0;
                und_q  <= ~tx_valid;
                lsb_q  <= lsb_first;
                cnt_q  <= '0;
                txd_q  <= 1'b0;
            end else if (tx_edge) begin
                if (bits_left) begin
                    txd_q  <= next_bit;
                    sreg_q <= sreg_shifted;
                    cnt_q  <= cnt_q + 1'b1;
                end else begin
                    txd_q <= 1'b0;
                end
            end
        end
    end

    assign txd         = txd_q;
    assign tx_underrun = und_q;

endmodule

// File: rtl/codec_rx_des.sv
module codec_rx_des
    import codec_shift_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         frame_start,
    input  logic         tx_edge,
    input  logic         rx_edge,
    input  logic         lsb_first,
    input  logic         rxd,
    output logic [W-1:0] rx_word,
    output logic         rx_valid
);

    localparam int            CW    = $clog2(W + 1);
    localparam logic [CW-1:0] FINAL = CW'(W - 1);
    localparam logic [CW-1:0] TOP   = CW'(W - 1);

    rx_state_t     st_q, st_d;
    logic [W-1:0]  acc_q;
    logic [W-1:0]  acc_d;
    logic [CW-1:0] cnt_q;
    logic [CW-1:0] slot_idx;
    logic          lsb_q;
    logic [W-1:0]  word_q;
    logic          valid_q;
    logic          take;

    assign take     = (st_q == RX_SHIFT) && rx_edge && !frame_start;
    assign slot_idx = lsb_q ? cnt_q : (TOP - cnt_q);

    always_comb begin
        acc_d = acc_q;
        for (int i = 0; i < W; i++) begin
            if (slot_idx == CW'(i)) acc_d[i] = rxd;
        end
    end

    // next-state logic
    always_comb begin
        st_d = st_q;
        if (frame_start) begin
            st_d = RX_ARMED;
        end else begin
            unique case (st_q)
                RX_IDLE:  st_d = RX_IDLE;
                RX_ARMED: st_d = tx_edge ? RX_SHIFT : RX_ARMED;
                RX_SHIFT: st_d = (rx_edge && cnt_q == FINAL) ? RX_IDLE : RX_SHIFT;
                default:  st_d = RX_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= RX_IDLE;
        else        st_q <= st_d;
    end

    // datapath and outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_q   <= '0;
            cnt_q   <= '0;
            lsb_q   <= 1'b0;
            word_q  <= '0;
            valid_q <= 1'b0;
        end else begin
            valid_q <= 1'b0;
            if (frame_start) begin
                acc_q <= '0;
                cnt_q <= '0;
                lsb_q <= lsb_first;
            end else if (take) begin
                acc_q <= acc_d;
                cnt_q <= cnt_q + 1'b1;
                if (cnt_q == FINAL) begin
                    word_q  <= acc_d;
                    valid_q <= 1'b1;
                end
            end
        end
    end

    assign rx_word  = word_q;
    assign rx_valid = valid_q;

endmodule

// File: rtl/codec_shifter.sv
module codec_shifter #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         cfg_clk_pol,
    input  logic         cfg_lsb_first,
    input  logic         cfg_fs_pol,
    input  logic         tx_en,
    input  logic [W-1:0] tx_word,
    input  logic         tx_valid,
    output logic         tx_ready,
    output logic         txd,
    input  logic         rxd,
    output logic [W-1:0] rx_word,
    output logic         rx_valid,
    output logic         tx_underrun,
    input  logic         bclk_rise,
    input  logic         bclk_fall,
    input  logic         fsync
);

    logic tx_edge;
    logic rx_edge;
    logic frame_start;

    codec_edge_sel edge_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .bclk_rise   (bclk_rise),
        .bclk_fall   (bclk_fall),
        .fsync       (fsync),
        .clk_pol     (cfg_clk_pol),
        .fs_pol      (cfg_fs_pol),
        .tx_edge     (tx_edge),
        .rx_edge     (rx_edge),
        .frame_start (frame_start)
    );

    codec_tx_ser #(.W(W)) tx_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .tx_en       (tx_en),
        .frame_start (frame_start),
        .tx_edge     (tx_edge),
        .lsb_first   (cfg_lsb_first),
        .tx_valid    (tx_valid),
        .tx_word     (tx_word),
        .txd         (txd),
        .tx_underrun (tx_underrun)
    );

    codec_rx_des #(.W(W)) rx_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .frame_start (frame_start),
        .tx_edge     (tx_edge),
        .rx_edge     (rx_edge),
        .lsb_first   (cfg_lsb_first),
        .rxd         (rxd),
        .rx_word     (rx_word),
        .rx_valid    (rx_valid)
    );

    assign tx_ready = frame_start & tx_en;

endmodule

// File: rtl/codec_shifter_chk.sv
module codec_shifter_chk #(
    parameter int W = 16
) (
    input logic         clk,
    input logic         rst_n,
    input logic         cfg_clk_pol,
    input logic         tx_en,
    input logic         tx_valid,
    input logic         tx_ready,
    input logic         txd,
    input logic         tx_underrun,
    input logic         rx_valid,
    input logic [W-1:0] rx_word,
    input logic         bclk_rise,
    input logic         bclk_fall,
    input logic         frame_start
);

    logic launch;
    assign launch = cfg_clk_pol ? bclk_fall : bclk_rise;

    // R2: the strobes from the clock generator never coincide
    a_r2_edges_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(bclk_rise && bclk_fall));

    // R2: txd moves only after a launch edge, a frame start or a disable
    a_r2_txd_on_launch: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(txd) |-> $past(launch || frame_start || !tx_en));

    // R7: a disabled transmitter drives low
    a_r7_disabled_low: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_en |=> !txd);

    // R4: acceptance is a single-cycle event
    a_r4_ready_single: assert property (@(posedge clk) disable iff (!rst_n)
        tx_ready |=> !tx_ready);

    // R8: an underrun follows a start that had no word
    a_r8_underrun_cause: assert property (@(posedge clk) disable iff (!rst_n)
        tx_underrun |-> $past(frame_start && tx_en && !tx_valid));

    // R10: receive strobe lasts one cycle
    a_r10_valid_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid);

    // R10: the received word holds between strobes
    a_r10_word_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_valid |-> $stable(rx_word));

endmodule

bind codec_shifter codec_shifter_chk #(.W(W)) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg_clk_pol (cfg_clk_pol),
    .tx_en       (tx_en),
    .tx_valid    (tx_valid),
    .tx_ready    (tx_ready),
    .txd         (txd),
    .tx_underrun (tx_underrun),
    .rx_valid    (rx_valid),
    .rx_word     (rx_word),
    .bclk_rise   (bclk_rise),
    .bclk_fall   (bclk_fall),
    .frame_start (frame_start)
);

// File: tb/codec_shifter_tb_top.sv
module codec_shifter_tb_top;

    localparam int W = 16;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         cfg_clk_pol = 1'b0;
    logic         cfg_lsb_first = 1'b0;
    logic         cfg_fs_pol = 1'b1;
    logic         tx_en = 1'b1;
    logic [W-1:0] tx_word = '0;
    logic         tx_valid = 1'b0;
    logic         tx_ready;
    logic         txd;
    logic         rxd = 1'b0;
    logic [W-1:0] rx_word;
    logic         rx_valid;
    logic         tx_underrun;
    logic         bclk_rise = 1'b0;
    logic         bclk_fall = 1'b0;
    logic         fsync = 1'b0;

    int  errors = 0;
    int  checks = 0;
    bit  chk_on = 1'b0;
    bit  done = 1'b0;

    always #2 clk = ~clk;

    codec_shifter #(.W(W)) dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_clk_pol(cfg_clk_pol),
        .cfg_lsb_first(cfg_lsb_first), .cfg_fs_pol(cfg_fs_pol),
        .tx_en(tx_en), .tx_word(tx_word), .tx_valid(tx_valid),
        .tx_ready(tx_ready), .txd(txd), .rxd(rxd), .rx_word(rx_word),
        .rx_valid(rx_valid), .tx_underrun(tx_underrun),
        .bclk_rise(bclk_rise), .bclk_fall(bclk_fall), .fsync(fsync)
    );

    // ---------------- behavioural reference ----------------
    bit           m_fs_prev;
    int           m_tx_mode;   // 0 idle, 1 waiting first launch, 2 sending
    bit           m_txq[$];
    bit           m_txd, m_und, m_rv;
    logic [W-1:0] m_rw, m_racc;
    int           m_rmode, m_rcnt;
    bit           m_rlsb;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_fs_prev = 1'b1; m_tx_mode = 0; m_txq.delete();
            m_txd = 0; m_und = 0; m_rv = 0; m_rw = '0; m_racc = '0;
            m_rmode = 0; m_rcnt = 0; m_rlsb = 0;
        end else begin
            bit fa, st, te, re;
            fa = (fsync == cfg_fs_pol);
            st = fa && !m_fs_prev;
            m_fs_prev = fa;
            te = cfg_clk_pol ? bclk_fall : bclk_rise;
            re = cfg_clk_pol ? bclk_rise : bclk_fall;
            m_und = 0;
            m_rv  = 0;
            if (!tx_en) begin
                m_tx_mode = 0; m_txd = 0; m_txq.delete();
            end else if (st) begin
                m_tx_mode = 1; m_txd = 0; m_txq.delete();
                m_und = !tx_valid;
                for (int i = 0; i < W; i++) begin
                    int b;
                    b = cfg_lsb_first ? i : W - 1 - i;
                    m_txq.push_back(tx_valid ? tx_word[b] : 1'b0);
                end
            end else if (te && m_tx_mode != 0) begin
                if (m_txq.size() > 0) begin
                    m_txd = m_txq.pop_front();
                    m_tx_mode = 2;
                end else begin
                    m_txd = 0;
                    m_tx_mode = 0;
                end
            end
            if (st) begin
                m_rmode = 1; m_rcnt = 0; m_racc = '0; m_rlsb = cfg_lsb_first;
            end else if (m_rmode == 1 && te) begin
                m_rmode = 2;
            end else if (m_rmode == 2 && re) begin
                m_racc[m_rlsb ? m_rcnt : W - 1 - m_rcnt] = rxd;
                m_rcnt++;
                if (m_rcnt == W) begin
                    m_rw = m_racc; m_rv = 1; m_rmode = 0;
                end
            end
        end
    end

    task automatic chk1(input logic act, input logic exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s at %0t: actual=%0b expected=%0b", tag, $time, act, exp);
        end
    endtask

    task automatic chkw(input logic [W-1:0] act, input logic [W-1:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s at %0t: actual=%h expected=%h", tag, $time, act, exp);
        end
    endtask

    // compare every cycle, after new inputs settle and before the next edge
    always begin
        @(negedge clk);
        #1;
        if (chk_on) begin
            chk1(txd, m_txd, "R2 R5 R6 R7 R8 R11 txd");
            chk1(tx_ready, tx_en && (fsync == cfg_fs_pol) && !m_fs_prev, "R3 R4 tx_ready");
            chk1(tx_underrun, m_und, "R8 tx_underrun");
            chk1(rx_valid, m_rv, "R10 rx_valid");
            chkw(rx_word, m_rw, "R9 R10 R11 rx_word");
        end
    end

    // ---------------- stimulus ----------------
    task automatic cyc(input bit r, input bit f, input bit fs_on, input bit v);
        @(negedge clk);
        bclk_rise = r;
        bclk_fall = f;
        fsync     = fs_on ? cfg_fs_pol : !cfg_fs_pol;
        tx_valid  = v;
        rxd       = 1'($urandom);
    endtask

    task automatic set_cfg(input bit pol, input bit lsb, input bit fsp);
        @(negedge clk);
        cfg_clk_pol   = pol;
        cfg_lsb_first = lsb;
        cfg_fs_pol    = fsp;
        fsync         = !fsp;
        bclk_rise     = 0;
        bclk_fall     = 0;
    endtask

    // one frame: start cycle, then nper bit periods, sync active in the first
    task automatic frame(input logic [W-1:0] word, input bit v, input int nper);
        tx_word = word;
        cyc(0, 0, 0, v);
        cyc(0, 0, 1, v);
        for (int p = 0; p < nper; p++) begin
            cyc(1, 0, p == 0, 0);
            cyc(0, 0, p == 0, 0);
            cyc(0, 1, p == 0, 0);
            cyc(0, 0, p == 0, 0);
        end
    endtask

    task automatic report();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        #1;
        // R1: values held during reset
        chk1(txd, 1'b0, "R1 txd");
        chk1(tx_ready, 1'b0, "R1 tx_ready");
        chk1(tx_underrun, 1'b0, "R1 tx_underrun");
        chk1(rx_valid, 1'b0, "R1 rx_valid");
        chkw(rx_word, '0, "R1 rx_word");
        @(negedge clk);
        rst_n = 1'b1;
        chk_on = 1'b1;

        // R2 R5: launch on rise, MSB first, active-high sync
        set_cfg(0, 0, 1);
        frame(16'hA5C3, 1, W + 2);
        // R2 R3 R5: launch on fall, LSB first, active-low sync
        set_cfg(1, 1, 0);
        frame(16'h1E7B, 1, W + 2);
        // R8: no word at frame start
        frame(16'hFFFF, 0, W + 2);
        // R11: restart in the middle of a word
        set_cfg(0, 1, 1);
        frame(16'h8001, 1, 6);
        frame(16'h7FFE, 1, W + 2);
        // R7 R10: disable mid-slot, receiver keeps running
        set_cfg(1, 0, 1);
        tx_word = 16'hC3C3;
        cyc(0, 0, 0, 1);
        cyc(0, 0, 1, 1);
        for (int p = 0; p < W + 2; p++) begin
            if (p == 5) tx_en = 1'b0;
            if (p == 9) tx_en = 1'b1;
            cyc(1, 0, p == 0, 0);
            cyc(0, 0, p == 0, 0);
            cyc(0, 1, p == 0, 0);
            cyc(0, 0, p == 0, 0);
        end
        // R7: start seen while disabled gives no slot
        tx_en = 1'b0;
        frame(16'hFFFF, 1, 4);
        tx_en = 1'b1;
        // assorted frames in all modes
        for (int k = 0; k < 16; k++) begin
            set_cfg(k[0], k[1], k[2]);
            frame(16'($urandom), k[3] | k[0], W + 2);
        end
        repeat (4) cyc(0, 0, 0, 0);
        done = 1'b1;
        report();
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL R1 watchdog: actual=running expected=finished");
            report();
        end
    end

endmodule